// File: doc/BRIEF.md
# Exposure Window and Integrate Sync Controller

This block times the charge-collection period of an image sensor. It runs in the fast system clock domain. A slow unit-integration clock (one tick per millisecond in the target system) arrives as a level, and the block counts its rising edges. A frame sequencer pulses `start`. The block waits a fixed lead-in of two ticks and then opens the exposure window. It closes the window either after a preset number of ticks or on a rising edge of an external stop line. After a fixed two-tick tail it returns a one-cycle `done` pulse.

During the window the `integrate` output can be:
- held high for the whole window,
- held low for the whole window, or
- driven as a burst of pulses with a two-tick period. Each pulse is low for its first tick and high for its second.

The mode, preset index and pulse code are captured when the start is accepted. Later changes on those pins do not affect the running exposure.

Top module: `integ_ctrl`

## Requirements
- R1: A tick is a rising edge of `unit_clk` seen in the system domain. A tick acts on the same system edge at which `unit_clk` is first sampled high. A level held high for many cycles counts as exactly one tick.
- R2: `start` is accepted only while the block is idle. Accepting it captures `ext_mode`, `preset_sel` and `pulse_code`. A `start` while busy is ignored, and a tick at the accepting edge is not counted.
- R3: The window opens on the second tick after the start is accepted. `integrate` is low before that tick.
- R4: With `ext_mode`=0, the window lasts N ticks. N is indexed by `preset_sel` 0..31 as 1,2,3,4,5,7,10,14,19,23,39,67,89,100,125,150,189,200,250,300,322,400,489,739,989,1489,1989,4989,9989,14989,29989,59989.
- R5: With `ext_mode`=1, the window closes on the third system clock edge after `ext_stop` rises, because of a two-flop synchroniser plus an edge detector. A rise of `ext_stop` has no effect when `ext_mode`=0 was captured.
- R6: `done` is high for exactly one cycle. That cycle follows the edge of the second tick after the window closed, and the block is idle in the next cycle.
- R7: With `pulse_code` 0, `integrate` is high throughout the window. With code 15, it stays low throughout.
- R8: With codes 1..14, the pulse count P is 1,2,3,4,5,10,20,30,40,50,75,100,150,200 in code order. While the window is open and e ticks of it have elapsed (e counted from 0), `integrate` is high exactly when e is odd and e/2 < P. After that it stays low, and the window is not extended.
- R9: Changes on `ext_mode`, `preset_sel` or `pulse_code` after the start is accepted do not change the running exposure.
- R10: While `rst_n` is low, and after its release until a start is accepted, `integrate` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| unit_clk | input | 1 | Unit-integration clock level, same domain as `clk` |
| start | input | 1 | Request from the frame sequencer to begin an exposure |
| ext_mode | input | 1 | 1: the window ends on the external stop line; 0: the window length comes from the preset |
| preset_sel | input | 5 | Preset exposure index |
| pulse_code | input | 4 | Output shape code |
| ext_stop | input | 1 | Asynchronous external end-of-exposure line |
| integrate | output | 1 | Exposure sync output |
| done | output | 1 | One-cycle completion pulse to the sequencer |

## Verification
Random preset indices from the short end of the table are combined with every pulse code. This separates steady, held-low and pulsed output, and shows whether a burst is cut short by a window that is too brief.

Directed runs cover the following cases, each of which exposes a different fault:
- The 200-pulse burst inside a 400-tick window checks the full pulse count.
- A unit clock with a long high phase catches a level that is counted more than once.
- External-mode runs with the stop line raised at different points check the fixed three-edge synchroniser latency.
- Internal-mode runs with the stop line toggled check that the line is ignored.
- Runs that churn the configuration pins and `start` mid-exposure separate captured settings from live ones.

// File: rtl/integ_pkg.sv
package integ_pkg;

  localparam int IDX_W  = 5;
  localparam int CODE_W = 4;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LEAD,
    PH_OPEN,
    PH_TAIL,
    PH_DONE
  } phase_t;

  typedef struct packed {
    logic              ext;
    logic [IDX_W-1:0]  idx;
    logic [CODE_W-1:0] code;
  } expo_cfg_t;

  // Exposure length in unit ticks for a preset index.
  function automatic logic [15:0] preset_ticks(input logic [IDX_W-1:0] sel);
    logic [15:0] t;
    case (sel)
      5'd0:  t = 16'd1;
      5'd1:  t = 16'd2;
      5'd2:  t = 16'd3;
      5'd3:  t = 16'd4;
      5'd4:  t = 16'd5;
      5'd5:  t = 16'd7;
      5'd6:  t = 16'd10;
      5'd7:  t = 16'd14;
      5'd8:  t = 16'd19;
      5'd9:  t = 16'd23;
      5'd10: t = 16'd39;
      5'd11: t = 16'd67;
      5'd12: t = 16'd89;
      5'd13: t = 16'd100;
      5'd14: t = 16'd125;
      5'd15: t = 16'd150;
      5'd16: t = 16'd189;
      5'd17: t = 16'd200;
      5'd18: t = 16'd250;
      5'd19: t = 16'd300;
      5'd20: t = 16'd322;
      5'd21: t = 16'd400;
      5'd22: t = 16'd489;
      5'd23: t = 16'd739;
      5'd24: t = 16'd989;
      5'd25: t = 16'd1489;
      5'd26: t = 16'd1989;
      5'd27: t = 16'd4989;
      5'd28: t = 16'd9989;
      5'd29: t = 16'd14989;
      5'd30: t = 16'd29989;
      default: t = 16'd59989;
    endcase
    return t;
  endfunction

  // Number of pulses for a burst code; 0 for the steady codes.
  function automatic logic [7:0] pulse_limit(input logic [CODE_W-1:0] c);
    logic [7:0] n;
    case (c)
      4'd1:  n = 8'd1;
      4'd2:  n = 8'd2;
      4'd3:  n = 8'd3;
      4'd4:  n = 8'd4;
      4'd5:  n = 8'd5;
      4'd6:  n = 8'd10;
      4'd7:  n = 8'd20;
      4'd8:  n = 8'd30;
      4'd9:  n = 8'd40;
      4'd10: n = 8'd50;
      4'd11: n = 8'd75;
      4'd12: n = 8'd100;
      4'd13: n = 8'd150;
      4'd14: n = 8'd200;
      default: n = 8'd0;
    endcase
    return n;
  endfunction

  function automatic logic is_burst(input logic [CODE_W-1:0] c);
    return (c != '0) && (c != '1);
  endfunction

endpackage

// File: rtl/integ_edge_det.sv
module integ_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);

  generate
    if (STAGES == 0) begin : g_direct
      logic last_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= din;
      end
      assign rise = din & ~last_q;
    end else begin : g_sync
      logic [STAGES:0] pipe_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[STAGES-1:0], din};
      end
      assign rise = pipe_q[STAGES-1] & ~pipe_q[STAGES];
    end
  endgenerate

  // R1: one event per rising level, never two cycles in a row
  a_r1_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/integ_phase_seq.sv
module integ_phase_seq
  import integ_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int LEAD_TICKS = 2,
  parameter int TAIL_TICKS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             tick,
  input  logic             ext_ev,
  input  expo_cfg_t        cfg_in,
  output expo_cfg_t        cfg_q,
  output phase_t           phase,
  output logic             window,
  output logic [CNT_W-1:0] elapsed,
  output logic             done
);

  localparam logic [CNT_W-1:0] LEAD_LAST = CNT_W'(LEAD_TICKS - 1);
  localparam logic [CNT_W-1:0] TAIL_LAST = CNT_W'(TAIL_TICKS - 1);
  localparam logic [CNT_W-1:0] CNT_MAX   = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] win_last;

  assign win_last = CNT_W'(preset_ticks(cfg_q.idx)) - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt_q <= '0;
      cfg_q <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (start) begin
          phase <= PH_LEAD;
          cnt_q <= '0;
          cfg_q <= cfg_in;
        end
        PH_LEAD: if (tick) begin
          if (cnt_q == LEAD_LAST) begin
            phase <= PH_OPEN;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_OPEN: begin
          if (cfg_q.ext) begin
            if (ext_ev) begin
              phase <= PH_TAIL;
              cnt_q <= '0;
            end else if (tick && cnt_q != CNT_MAX) begin
              cnt_q <= cnt_q + 1'b1;
            end
          end else if (tick) begin
            if (cnt_q == win_last) begin
              phase <= PH_TAIL;
              cnt_q <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        PH_TAIL: if (tick) begin
          if (cnt_q == TAIL_LAST) begin
            phase <= PH_DONE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_DONE: begin
          phase <= PH_IDLE;
          cnt_q <= '0;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign window  = (phase == PH_OPEN);
  assign elapsed = window ? cnt_q : '0;
  assign done    = (phase == PH_DONE);

  // R2: captured configuration frozen while busy
  a_r2_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE) && $past(phase != PH_IDLE) |-> $stable(cfg_q));

  // R6: completion pulse lasts one cycle
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/integ_pulse_shaper.sv
module integ_pulse_shaper
  import integ_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              window,
  input  logic [CNT_W-1:0]  elapsed,
  input  logic [CODE_W-1:0] code,
  output logic              integrate
);

  logic [CNT_W-1:0] pair_idx;
  logic [CNT_W-1:0] limit;

  assign pair_idx = elapsed >> 1;
  assign limit    = CNT_W'(pulse_limit(code));

  always_comb begin
    if (!window)              integrate = 1'b0;
    else if (code == '0)      integrate = 1'b1;
    else if (code == '1)      integrate = 1'b0;
    else                      integrate = elapsed[0] && (pair_idx < limit);
  end

endmodule

// File: rtl/integ_ctrl.sv
module integ_ctrl
  import integ_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int LEAD_TICKS = 2,
  parameter int TAIL_TICKS = 2,
  parameter int EXT_SYNC   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       unit_clk,
  input  logic       start,
  input  logic       ext_mode,
  input  logic [4:0] preset_sel,
  input  logic [3:0] pulse_code,
  input  logic       ext_stop,
  output logic       integrate,
  output logic       done
);

  logic             tick_ev;
  logic             ext_ev;
  expo_cfg_t        cfg_in;
  expo_cfg_t        cfg_q;
  phase_t           phase;
  logic             window;
  logic [CNT_W-1:0] elapsed;

  assign cfg_in = '{ext: ext_mode, idx: preset_sel, code: pulse_code};

  integ_edge_det #(.STAGES(0)) i_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (unit_clk),
    .rise (tick_ev)
  );

  integ_edge_det #(.STAGES(EXT_SYNC)) i_ext (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (ext_stop),
    .rise (ext_ev)
  );

  integ_phase_seq #(
    .CNT_W     (CNT_W),
    .LEAD_TICKS(LEAD_TICKS),
    .TAIL_TICKS(TAIL_TICKS)
  ) i_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .tick   (tick_ev),
    .ext_ev (ext_ev),
    .cfg_in (cfg_in),
    .cfg_q  (cfg_q),
    .phase  (phase),
    .window (window),
    .elapsed(elapsed),
    .done   (done)
  );

  integ_pulse_shaper #(.CNT_W(CNT_W)) i_shape (
    .window   (window),
    .elapsed  (elapsed),
    .code     (cfg_q.code),
    .integrate(integrate)
  );

  // Checker state: rising edges of integrate seen in the current window
  logic       integ_d;
  logic [7:0] pulses_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      integ_d     <= 1'b0;
      pulses_seen <= '0;
    end else begin
      integ_d <= integrate;
      if (!window)                   pulses_seen <= '0;
      else if (integrate && !integ_d) pulses_seen <= pulses_seen + 1'b1;
    end
  end

  // R3: the window only opens on a unit tick
  a_r3_open_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(window) |-> $past(tick_ev));

  // R4: preset windows only close on a unit tick
  a_r4_close_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(window) && !cfg_q.ext |-> $past(tick_ev));

  // R5: external windows only close on a synchronised stop edge
  a_r5_close_on_ext: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(window) && cfg_q.ext |-> $past(ext_ev));

  generate
    if (EXT_SYNC == 2) begin : g_sync_chk
      // R5: stop event trails the pin by the synchroniser depth
      a_r5_sync_latency: assert property (@(posedge clk) disable iff (!rst_n)
        ext_ev |-> $past(ext_stop, 2));
    end
  endgenerate

  // R6: completion follows a tail tick
  a_r6_done_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(tick_ev));

  // R8: burst never exceeds its coded pulse count
  a_r8_pulse_budget: assert property (@(posedge clk) disable iff (!rst_n)
    window && is_burst(cfg_q.code) |-> pulses_seen <= pulse_limit(cfg_q.code));

  // R10: outputs quiet while idle
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> !integrate && !done);

endmodule

// File: tb/test_integ_ctrl.sv
module test_integ_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       unit_clk = 1'b0;
  logic       start = 1'b0;
  logic       ext_mode = 1'b0;
  logic [4:0] preset_sel = '0;
  logic [3:0] pulse_code = '0;
  logic       ext_stop = 1'b0;
  logic       integrate;
  logic       done;

  integ_ctrl i_integ_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .unit_clk  (unit_clk),
    .start     (start),
    .ext_mode  (ext_mode),
    .preset_sel(preset_sel),
    .pulse_code(pulse_code),
    .ext_stop  (ext_stop),
    .integrate (integrate),
    .done      (done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit finished = 0;

  // Reference tables restated from the requirements
  function automatic int ref_window(int sel);
    int w [32] = '{1, 2, 3, 4, 5, 7, 10, 14, 19, 23, 39, 67, 89, 100, 125, 150,
                   189, 200, 250, 300, 322, 400, 489, 739, 989, 1489, 1989,
                   4989, 9989, 14989, 29989, 59989};
    return w[sel];
  endfunction

  function automatic int ref_pulses(int c);
    int p [16] = '{0, 1, 2, 3, 4, 5, 10, 20, 30, 40, 50, 75, 100, 150, 200, 0};
    return p[c];
  endfunction

  function automatic bit ref_level(int c, int e);
    if (c == 0)  return 1'b1;
    if (c == 15) return 1'b0;
    return (e % 2 == 1) && (e / 2 < ref_pulses(c));
  endfunction

  task automatic check(bit got, bit exp, string req, string what);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0b expected %0b at t=%0t", req, what, got, exp, $time);
    end
  endtask

  // Model state (0 idle,1 lead,2 open,3 tail,4 done)
  int m_ph = 0;
  int m_cnt = 0;
  int m_e = 0;
  bit m_ext = 0;
  int m_sel = 0;
  int m_code = 0;
  int ext_age = 0;
  bit rise_pend = 0;
  bit start_pend = 0;
  string run_tag = "R4";

  // Unit clock shape
  int u_lo = 3;
  int u_hi = 3;
  int u_ph = 0;

  task automatic drive_unit();
    bit nv;
    u_ph = (u_ph + 1) % (u_lo + u_hi);
    nv = (u_ph >= u_lo);
    rise_pend = nv && !unit_clk;
    unit_clk = nv;
  endtask

  task automatic model_edge();
    if (ext_stop) ext_age++;
    else          ext_age = 0;
    case (m_ph)
      0: if (start_pend) begin
        m_ph = 1; m_cnt = 0;
        m_ext = ext_mode; m_sel = preset_sel; m_code = pulse_code;
      end
      1: if (rise_pend) begin
        m_cnt++;
        if (m_cnt == 2) begin m_ph = 2; m_e = 0; end
      end
      2: begin
        if (m_ext && ext_age == 3) begin
          m_ph = 3; m_cnt = 0;
        end else if (rise_pend) begin
          m_e++;
          if (!m_ext && m_e == ref_window(m_sel)) begin m_ph = 3; m_cnt = 0; end
        end
      end
      3: if (rise_pend) begin
        m_cnt++;
        if (m_cnt == 2) m_ph = 4;
      end
      default: m_ph = 0;
    endcase
  endtask

  task automatic step();
    string tag;
    @(negedge clk);
    model_edge();
    case (m_ph)
      0: tag = "R10";
      1: tag = "R3";
      2: tag = run_tag;
      default: tag = "R6";
    endcase
    check(integrate, (m_ph == 2) && ref_level(m_code, m_e), tag, "integrate");
    check(done, (m_ph == 4), "R6", "done");
    drive_unit();
  endtask

  // One exposure; ext_after < 0 means the stop line is never raised
  task automatic run_exp(bit ext, int sel, int code, int ext_after,
                         bit disturb, bit restart, string tag);
    int guard = 0;
    run_tag = tag;
    ext_mode = ext; preset_sel = 5'(sel); pulse_code = 4'(code);
    start = 1'b1; start_pend = 1'b1;
    step();
    start = 1'b0; start_pend = 1'b0;
    while (m_ph != 0 && guard < 20000) begin
      step();
      guard++;
      if (m_ph == 2 && ext_after >= 0 && m_e >= ext_after) ext_stop = 1'b1;
      if (disturb && (m_ph == 1 || m_ph == 2)) begin
        ext_mode = 1'($urandom); preset_sel = 5'($urandom); pulse_code = 4'($urandom);
      end
      if (restart && (m_ph == 1 || m_ph == 2)) start = 1'($urandom);
      else start = 1'b0;
      start_pend = start;
    end
    if (m_ph != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL %s run did not finish: got phase %0d expected 0", tag, m_ph);
    end
    start = 1'b0; start_pend = 1'b0; ext_stop = 1'b0;
    for (int k = 0; k < 5; k++) step();
  endtask

  initial begin
    void'($urandom(32'd4242));
    // R10: reset state
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(integrate, 1'b0, "R10", "integrate in reset");
      check(done, 1'b0, "R10", "done in reset");
      drive_unit();
    end
    rst_n = 1'b1;
    for (int k = 0; k < 6; k++) step();

    // R4: shortest preset windows, steady output
    run_exp(0, 0, 0, -1, 0, 0, "R4");
    run_exp(0, 1, 0, -1, 0, 0, "R4");
    run_exp(0, 6, 0, -1, 0, 0, "R4");
    // R7: held-low code
    run_exp(0, 5, 15, -1, 0, 0, "R7");
    // R8: bursts, including one cut short and the largest count
    run_exp(0, 8, 6, -1, 0, 0, "R8");
    run_exp(0, 2, 3, -1, 0, 0, "R8");
    run_exp(0, 21, 14, -1, 0, 0, "R8");
    // R5: external close at several points, and ignored in preset mode
    run_exp(1, 0, 0, 0, 0, 0, "R5");
    run_exp(1, 3, 0, 7, 0, 0, "R5");
    run_exp(1, 31, 2, 5, 0, 0, "R5");
    run_exp(0, 9, 0, 3, 0, 0, "R5");
    // R9 and R2: churn on config pins and start during exposure
    run_exp(0, 7, 4, -1, 1, 0, "R9");
    run_exp(1, 2, 0, 9, 1, 0, "R9");
    run_exp(0, 6, 2, -1, 0, 1, "R2");
    // R1: unit level held high for a long time
    u_lo = 2; u_hi = 11; u_ph = 0;
    run_exp(0, 4, 0, -1, 0, 0, "R1");
    run_exp(0, 6, 5, -1, 0, 0, "R1");
    u_lo = 3; u_hi = 3; u_ph = 0;
    // Random mix
    for (int r = 0; r < 24; r++) begin
      bit ext = 1'($urandom);
      int sel = $urandom % 13;
      int code = $urandom % 16;
      int ea = ext ? int'($urandom % 20) : ((($urandom % 3) == 0) ? int'($urandom % 6) : -1);
      u_lo = 1 + $urandom % 4;
      u_hi = 1 + $urandom % 4;
      u_ph = 0;
      run_exp(ext, sel, code, ea, 1'($urandom), 1'($urandom), code == 0 || code == 15 ? "R7" : "R8");
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    while (!finished) begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG && !finished) begin
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got %0d cycles expected at most %0d", cycles, WATCHDOG);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

endmodule